// File: doc/BRIEF.md
# Real-Time Clock Status and Interrupt Register

This block holds the read-only status byte of a real-time clock. Six sticky event flags are captured into it: a watchdog trip, entry into test mode, a power-on "first-time up" marker, a power-sense event, an alarm match and a periodic tick. A summary bit reports whether any of the three interrupt sources (power-sense, alarm, tick) is pending. The serial interface decodes the register address (0x30) and presents the byte through `rd_data`. It pulses `rd_strobe` for one cycle when the byte is read. That read clears every flag except power-sense, which only a reset removes.

The alarm comparator is part of the block. It compares the seconds, minutes and hours counters with the three alarm registers. A two-state machine drives it. In ARMED, a full match raises a one-cycle hit and moves the machine to FIRED (transition ARMED->FIRED). In FIRED, the machine waits until the counters differ from the alarm values and then returns to ARMED (transition FIRED->ARMED). As a result, a match that lasts many cycles raises the alarm flag only once.

Top module: `rtc_status_reg`

## Requirements
- R1: After reset, `rd_data` reads 0x20: the first-time-up bit D5 is 1 and every other bit is 0.
- R2: The bit positions are D7 watchdog, D6 test mode, D5 first-time up, D4 interrupt summary, D3 power-sense, D2 alarm and D1 tick. D0 always reads 0.
- R3: A one-cycle pulse on `wdog_evt`, `test_evt`, `pwr_evt` or `tick_evt` sets its bit at the next clock edge. The bit then stays set until it is cleared.
- R4: A cycle with `rd_strobe` high clears D7, D6, D5, D2 and D1 at the closing clock edge.
- R5: A read leaves the power-sense bit D3 unchanged. Only reset clears D3.
- R6: D4 is 1 exactly when at least one of D3, D2 or D1 is 1.
- R7: An event that arrives in the same cycle as a read leaves its bit set after that edge.
- R8: When the seconds, minutes and hours inputs all equal their alarm inputs, D2 is set at the next edge. A match on only some of the three fields sets nothing.
- R9: The alarm sets D2 only on the cycle in which a full match begins. A match that persists does not set D2 again after a read. A new alarm needs a mismatch followed by a new match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wdog_evt | input | 1 | Watchdog trip pulse |
| test_evt | input | 1 | Test-mode entry pulse |
| pwr_evt | input | 1 | Power-sense event pulse |
| tick_evt | input | 1 | Periodic tick pulse |
| now_sec | input | TIME_W | Current seconds counter |
| now_min | input | TIME_W | Current minutes counter |
| now_hr | input | TIME_W | Current hours counter |
| alm_sec | input | TIME_W | Alarm seconds value |
| alm_min | input | TIME_W | Alarm minutes value |
| alm_hr | input | TIME_W | Alarm hours value |
| rd_strobe | input | 1 | One-cycle read-of-register pulse |
| rd_data | output | 8 | Status byte |

## Verification
The bench builds the block with TIME_W = 6. That width covers the binary range of each time field, while the comparison is reduced to a few small fields that can be set in any combination. The reduced fields let the bench drive full and partial matches, hold a match across a read, and restart a match in the same cycle as a read. With the sticky flags, this reaches every state of the alarm machine and both of its transitions.

// File: rtl/rtc_status_pkg.sv
package rtc_status_pkg;

    // Index of each sticky flag inside the flag vector
    localparam int FLG_TICK  = 0;
    localparam int FLG_ALARM = 1;
    localparam int FLG_PWR   = 2;
    localparam int FLG_FIRST = 3;
    localparam int FLG_TEST  = 4;
    localparam int FLG_WDOG  = 5;
    localparam int NUM_FLAGS = 6;

    // Flags that survive a read, and flags that reset to 1
    localparam logic [NUM_FLAGS-1:0] KEEP_ON_READ = 6'b000100;
    localparam logic [NUM_FLAGS-1:0] SET_AT_RESET = 6'b001000;

    // Alarm detector states
    typedef enum logic [0:0] {
        ALM_ARMED = 1'b0,
        ALM_FIRED = 1'b1
    } alm_state_t;

endpackage

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell #(
    parameter bit CLR_ON_READ = 1'b1,
    parameter bit RST_VAL     = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_clr_i,
    output logic q_o
);

    logic q_d;

    // A set in the same cycle as a clearing read wins.
    always_comb begin
        q_d = q_o;
        if (CLR_ON_READ && rd_clr_i)
            q_d = 1'b0;
        if (set_i)
            q_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= RST_VAL;
        else
            q_o <= q_d;
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_status_pkg::*;
#(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] now_sec,
    input  logic [TIME_W-1:0] now_min,
    input  logic [TIME_W-1:0] now_hr,
    input  logic [TIME_W-1:0] alm_sec,
    input  logic [TIME_W-1:0] alm_min,
    input  logic [TIME_W-1:0] alm_hr,
    output logic              hit_o
);

    localparam int NFIELD = 3;

    logic [NFIELD-1:0] [TIME_W-1:0] now_f;
    logic [NFIELD-1:0] [TIME_W-1:0] alm_f;
    logic [NFIELD-1:0]              fld_eq;
    logic                           all_eq;
    alm_state_t                     state_q;
    alm_state_t                     state_d;

    assign now_f = {now_hr, now_min, now_sec};
    assign alm_f = {alm_hr, alm_min, alm_sec};

    for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
        assign fld_eq[g] = (now_f[g] == alm_f[g]);
    end

    assign all_eq = &fld_eq;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ALM_ARMED;
        else
            state_q <= state_d;
    end

    // Next state and output
    always_comb begin
        state_d = state_q;
        hit_o   = 1'b0;
        unique case (state_q)
            ALM_ARMED: begin
                if (all_eq) begin
                    hit_o   = 1'b1;
                    state_d = ALM_FIRED;
                end
            end
            ALM_FIRED: begin
                if (!all_eq)
                    state_d = ALM_ARMED;
            end
            default: state_d = ALM_ARMED;
        endcase
    end

endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
    import rtc_status_pkg::*;
#(
    parameter int TIME_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wdog_evt,
    input  logic              test_evt,
    input  logic              pwr_evt,
    input  logic              tick_evt,
    input  logic [TIME_W-1:0] now_sec,
    input  logic [TIME_W-1:0] now_min,
    input  logic [TIME_W-1:0] now_hr,
    input  logic [TIME_W-1:0] alm_sec,
    input  logic [TIME_W-1:0] alm_min,
    input  logic [TIME_W-1:0] alm_hr,
    input  logic              rd_strobe,
    output logic [7:0]        rd_data
);

    logic                 alarm_hit;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 irq_any;

    rtc_alarm_match #(.TIME_W(TIME_W)) u_alarm (
        .clk     (clk),
        .rst_n   (rst_n),
        .now_sec (now_sec),
        .now_min (now_min),
        .now_hr  (now_hr),
        .alm_sec (alm_sec),
        .alm_min (alm_min),
        .alm_hr  (alm_hr),
        .hit_o   (alarm_hit)
    );

    always_comb begin
        flag_set            = '0;
        flag_set[FLG_TICK]  = tick_evt;
        flag_set[FLG_ALARM] = alarm_hit;
        flag_set[FLG_PWR]   = pwr_evt;
        flag_set[FLG_FIRST] = 1'b0;
        flag_set[FLG_TEST]  = test_evt;
        flag_set[FLG_WDOG]  = wdog_evt;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        rtc_flag_cell #(
            .CLR_ON_READ (!KEEP_ON_READ[i]),
            .RST_VAL     (SET_AT_RESET[i])
        ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (flag_set[i]),
            .rd_clr_i (rd_strobe),
            .q_o      (flag_q[i])
        );
    end

    assign irq_any = flag_q[FLG_PWR] | flag_q[FLG_ALARM] | flag_q[FLG_TICK];

    // Output assembly
    always_comb begin
        rd_data    = '0;
        rd_data[7] = flag_q[FLG_WDOG];
        rd_data[6] = flag_q[FLG_TEST];
        rd_data[5] = flag_q[FLG_FIRST];
        rd_data[4] = irq_any;
        rd_data[3] = flag_q[FLG_PWR];
        rd_data[2] = flag_q[FLG_ALARM];
        rd_data[1] = flag_q[FLG_TICK];
        rd_data[0] = 1'b0;
    end

endmodule

// File: rtl/rtc_status_checker.sv
module rtc_status_checker #(
    parameter int TIME_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wdog_evt,
    input logic              test_evt,
    input logic              pwr_evt,
    input logic              tick_evt,
    input logic [TIME_W-1:0] now_sec,
    input logic [TIME_W-1:0] now_min,
    input logic [TIME_W-1:0] now_hr,
    input logic [TIME_W-1:0] alm_sec,
    input logic [TIME_W-1:0] alm_min,
    input logic [TIME_W-1:0] alm_hr,
    input logic              rd_strobe,
    input logic [7:0]        rd_data
);

    logic match_now;
    assign match_now = (now_sec == alm_sec) && (now_min == alm_min) && (now_hr == alm_hr);

    assert_first_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_data == 8'h20);

    assert_bit0_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0);

    assert_wdog_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_evt |=> rd_data[7]);

    assert_tick_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_evt |=> rd_data[1]);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && !wdog_evt && !test_evt |=> !rd_data[7] && !rd_data[6] && !rd_data[5]);

    assert_pwr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |=> rd_data[3]);

    assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] == (rd_data[3] | rd_data[2] | rd_data[1]));

    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && test_evt |=> rd_data[6]);

    assert_alarm_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        match_now && !$past(match_now) && $past(rst_n) |=> rd_data[2]);

    assert_alarm_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && match_now && $past(match_now) && $past(rst_n) |=> !rd_data[2]);

endmodule

bind rtc_status_reg rtc_status_checker #(.TIME_W(TIME_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdog_evt  (wdog_evt),
    .test_evt  (test_evt),
    .pwr_evt   (pwr_evt),
    .tick_evt  (tick_evt),
    .now_sec   (now_sec),
    .now_min   (now_min),
    .now_hr    (now_hr),
    .alm_sec   (alm_sec),
    .alm_min   (alm_min),
    .alm_hr    (alm_hr),
    .rd_strobe (rd_strobe),
    .rd_data   (rd_data)
);

// File: tb/rtc_status_reg_test.sv
module rtc_status_reg_test;

    localparam int TW = 6;
    localparam int NVEC = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wdog_evt = 1'b0, test_evt = 1'b0, pwr_evt = 1'b0, tick_evt = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [TW-1:0] now_sec = '0, now_min = '0, now_hr = '0;
    logic [TW-1:0] alm_sec = 6'd5, alm_min = 6'd5, alm_hr = 6'd5;
    logic [7:0]    rd_data;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    rtc_status_reg #(.TIME_W(TW)) uut (
        .clk(clk), .rst_n(rst_n),
        .wdog_evt(wdog_evt), .test_evt(test_evt), .pwr_evt(pwr_evt), .tick_evt(tick_evt),
        .now_sec(now_sec), .now_min(now_min), .now_hr(now_hr),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hr(alm_hr),
        .rd_strobe(rd_strobe), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    // Vector: {wdog, test, pwr, tick, rd} then expected rd_data after the edge
    localparam logic [12:0] VEC [NVEC] = '{
        {5'b00010, 8'h32},  // R3 tick, R6 summary
        {5'b00001, 8'h00},  // R4 read clears
        {5'b00100, 8'h18},  // R3 power
        {5'b00001, 8'h18},  // R5 power survives read
        {5'b10000, 8'h98},  // R3 watchdog
        {5'b01000, 8'hD8},  // R3 test
        {5'b00011, 8'h1A},  // R7 tick with read
        {5'b00001, 8'h18},  // R4
        {5'b10001, 8'h98},  // R7 watchdog with read
        {5'b00000, 8'h98},  // R3 holds
        {5'b00001, 8'h18}   // R4
    };

    task automatic check(input string req, input logic [7:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    // Drive at negedge, let the posedge capture, sample at next negedge
    task automatic step(input logic [4:0] ctl);
        {wdog_evt, test_evt, pwr_evt, tick_evt, rd_strobe} = ctl;
        @(negedge clk);
        {wdog_evt, test_evt, pwr_evt, tick_evt, rd_strobe} = 5'b0;
    endtask

    task automatic set_now(input logic [TW-1:0] s, input logic [TW-1:0] m, input logic [TW-1:0] h);
        now_sec = s; now_min = m; now_hr = h;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected=<5000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", 8'h20);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 8'h20);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][12:8]);
            check($sformatf("R2/vector %0d", i), VEC[i][7:0]);
        end

        // R8 partial match does nothing
        set_now(6'd5, 6'd5, 6'd4);
        step(5'b0);
        check("R8 partial match", 8'h18);
        // R8 full match sets alarm
        set_now(6'd5, 6'd5, 6'd5);
        step(5'b0);
        check("R8 full match", 8'h1C);
        // R9 read while match persists: no re-set
        step(5'b00001);
        check("R9 read during match", 8'h18);
        step(5'b0);
        check("R9 held match", 8'h18);
        // R9 mismatch then new match, arriving with a read (R7)
        set_now(6'd6, 6'd5, 6'd5);
        step(5'b0);
        check("R9 mismatch", 8'h18);
        set_now(6'd5, 6'd5, 6'd5);
        step(5'b00001);
        check("R9 rematch with read R7", 8'h1C);
        // R5 only reset clears power
        rst_n = 1'b0;
        @(negedge clk);
        check("R5 reset clears power", 8'h20);
        finish_run();
    end

endmodule